// File: doc/BRIEF.md
# Serial Supervisor Command Responder

This block is the protocol side of a board supervisor that talks to a host processor over a byte-wide serial link. The host sends short text frames. Each frame is a `#` start character, one command letter and a line feed. The block answers each accepted command with a `$`-framed reply. The reply repeats the command letter and carries the requested sensor readings as uppercase ASCII hex, taken from parallel inputs sampled while the reply is sent. A power-off request is raised for the shutdown command.

Accepted commands wait in a small queue and are answered strictly in arrival order. This lets the host issue several requests without waiting for each reply. The receive and transmit sides use valid/ready handshakes, so a separate bit-level serialiser can sit on either side.

A front-panel button input is also timed. Each press sends a fixed-length active-low interrupt pulse to the host. Holding the button long enough forces a power-off request.

Top module: `sup_cmd_responder`

## Requirements
- R1: A command is accepted only as the three bytes `#` (0x23), a letter, then line feed (0x0A). The letters are `s`, `t`, `v` and `f`. A second `#` after the start character restarts framing.
- R2: Frames that are malformed produce no reply and no power-off pulse. This covers an unknown letter, a missing `#`, an extra byte before the line feed, and a missing letter.
- R3: Accepted commands are queued up to Q_DEPTH deep and answered in arrival order. While the queue is full, rx_ready_o is low and no byte is taken.
- R4: Every reply is `$` (0x24), the command letter, the payload, then 0x0A. tx_data_o and tx_valid_o are held while tx_valid_o is high and tx_ready_i is low. The last byte of one reply and the first byte of the next are separated by at least one cycle with tx_valid_o low.
- R5: Command `s` is answered with `$s` and line feed. pwr_off_o is high for exactly one cycle for each `s` served.
- R6: Command `t` carries N_TEMP fields in index order: index 0 at temps_i[7:0] (board), index 1 at [15:8] (processor), index 2 at [23:16] (switch). Each input is a signed byte. Each field is `+` for zero or positive, or `-` for negative, followed by two hex digits of the magnitude, high digit first.
- R7: Command `v` carries N_VOLT fields. Field k comes from volts_i[16k+15:16k], high byte = whole volts and low byte = count of 10 mV units. Each field is four hex digits, most significant first.
- R8: Command `f` carries fan_pwm_i as two hex digits, then fan_rpm_i as four hex digits, most significant first.
- R9: A rising edge of button_i drives irq_n_o low for exactly CLK_PER_MS cycles. The pulse is first visible in the cycle after the edge where the press is first seen.
- R10: If button_i is seen high on CLK_PER_MS*HOLD_MS+1 consecutive clock edges, pwr_off_o pulses once, right after that edge. It does not pulse again while the button stays held.
- R11: After reset, tx_valid_o is low, irq_n_o is high, pwr_off_o is low and rx_ready_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_data_i | input | 8 | Received byte from host |
| rx_valid_i | input | 1 | Received byte is present |
| rx_ready_o | output | 1 | Block can take a byte |
| tx_data_o | output | 8 | Reply byte to host |
| tx_valid_o | output | 1 | Reply byte is present |
| tx_ready_i | input | 1 | Serialiser takes the byte |
| temps_i | input | 8*N_TEMP | Signed temperatures, index 0 in low byte |
| volts_i | input | 16*N_VOLT | Voltage readings, field 0 in low bits |
| fan_pwm_i | input | 8 | Fan duty value |
| fan_rpm_i | input | 16 | Fan speed |
| button_i | input | 1 | Debounced button, high while pressed |
| irq_n_o | output | 1 | Active-low interrupt pulse to host |
| pwr_off_o | output | 1 | One-cycle power-off request |

## Verification
The checks assume the serialiser never takes a byte that is not offered. They also assume button_i is already debounced and is low through reset, so a falling interrupt line can always be traced to a press seen on the two edges before it. The stimulus drives every input away from the clock edge. It releases the button for several cycles between presses. It changes sensor inputs only while no reply is in progress, so each expected reply can be built from the values then applied.

// File: rtl/sup_pkg.sv
package sup_pkg;
  typedef enum logic [1:0] {CMD_S = 2'd0, CMD_T = 2'd1, CMD_V = 2'd2, CMD_F = 2'd3} cmd_e;

  localparam logic [7:0] CH_RX_SOF = 8'h23;
  localparam logic [7:0] CH_TX_SOF = 8'h24;
  localparam logic [7:0] CH_EOF    = 8'h0A;

  function automatic logic [7:0] hex_ch(input logic [3:0] n);
    return (n < 4'd10) ? (8'h30 + {4'h0, n}) : (8'h37 + {4'h0, n});
  endfunction

  function automatic logic [7:0] cmd_letter(input cmd_e c);
    case (c)
      CMD_S:   return 8'h73;
      CMD_T:   return 8'h74;
      CMD_V:   return 8'h76;
      default: return 8'h66;
    endcase
  endfunction
endpackage

// File: rtl/sup_rx_parser.sv
module sup_rx_parser
  import sup_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] byte_i,
  input  logic       take_i,
  output logic       push_o,
  output logic [1:0] cmd_o
);
  typedef enum logic [1:0] {P_IDLE, P_HASH, P_LETTER} pst_e;
  pst_e st_q;
  cmd_e cmd_q;

  assign cmd_o = cmd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= P_IDLE;
      cmd_q  <= CMD_S;
      push_o <= 1'b0;
    end else begin
      push_o <= 1'b0;
      if (take_i) begin
        case (st_q)
          P_IDLE: if (byte_i == CH_RX_SOF) st_q <= P_HASH;
          P_HASH: begin
            st_q <= P_LETTER;
            case (byte_i)
              8'h73:     cmd_q <= CMD_S;
              8'h74:     cmd_q <= CMD_T;
              8'h76:     cmd_q <= CMD_V;
              8'h66:     cmd_q <= CMD_F;
              CH_RX_SOF: st_q  <= P_HASH;
              default:   st_q  <= P_IDLE;
            endcase
          end
          default: begin
            if (byte_i == CH_EOF) begin
              push_o <= 1'b1;
              st_q   <= P_IDLE;
            end else if (byte_i == CH_RX_SOF) begin
              st_q <= P_HASH;
            end else begin
              st_q <= P_IDLE;
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/sup_cmd_fifo.sv
module sup_cmd_fifo #(
  parameter int W     = 2,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push_i,
  input  logic [W-1:0] wdata_i,
  input  logic         pop_i,
  output logic [W-1:0] rdata_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign do_pop  = pop_i && !empty_o;
  assign do_push = push_i && (!full_o || do_pop);
  assign rdata_o = mem[rp_q];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= wdata_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
      if (do_pop)  rp_q <= (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/sup_resp_fmt.sv
module sup_resp_fmt
  import sup_pkg::*;
#(
  parameter int N_TEMP = 3,
  parameter int N_VOLT = 13
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  q_empty_i,
  input  logic [1:0]            q_cmd_i,
  output logic                  q_pop_o,
  input  logic [8*N_TEMP-1:0]   temps_i,
  input  logic [16*N_VOLT-1:0]  volts_i,
  input  logic [7:0]            pwm_i,
  input  logic [15:0]           rpm_i,
  output logic [7:0]            tx_data_o,
  output logic                  tx_valid_o,
  input  logic                  tx_ready_i,
  output logic                  shut_o
);
  localparam int LEN_S   = 3;
  localparam int LEN_T   = 3 + 3 * N_TEMP;
  localparam int LEN_V   = 3 + 4 * N_VOLT;
  localparam int LEN_F   = 9;
  localparam int MAX_TV  = (LEN_T > LEN_V) ? LEN_T : LEN_V;
  localparam int MAX_LEN = (MAX_TV > LEN_F) ? MAX_TV : LEN_F;
  localparam int IW      = $clog2(MAX_LEN + 1);

  cmd_e          cmd_q, sel_cmd, in_cmd;
  logic [IW-1:0] idx_q, sel_idx;
  logic [7:0]    nxt_byte;
  logic          advance;

  function automatic logic [IW-1:0] last_of(input cmd_e c);
    case (c)
      CMD_S:   return IW'(LEN_S - 1);
      CMD_T:   return IW'(LEN_T - 1);
      CMD_V:   return IW'(LEN_V - 1);
      default: return IW'(LEN_F - 1);
    endcase
  endfunction

  assign in_cmd  = cmd_e'(q_cmd_i);
  assign q_pop_o = !tx_valid_o && !q_empty_i;
  assign advance = tx_valid_o && tx_ready_i;
  assign sel_cmd = q_pop_o ? in_cmd : cmd_q;
  assign sel_idx = q_pop_o ? '0 : idx_q + 1'b1;

  always_comb begin : byte_gen
    int          p;
    int          fld;
    int          sub;
    logic [7:0]  t8;
    logic [7:0]  mag;
    logic [15:0] v16;
    logic [23:0] f24;
    p   = int'(sel_idx) - 2;
    fld = 0;
    sub = 0;
    t8  = '0;
    mag = '0;
    v16 = '0;
    f24 = {pwm_i, rpm_i};
    nxt_byte = CH_EOF;
    if (sel_idx == '0) begin
      nxt_byte = CH_TX_SOF;
    end else if (sel_idx == IW'(1)) begin
      nxt_byte = cmd_letter(sel_cmd);
    end else if (sel_idx != last_of(sel_cmd)) begin
      case (sel_cmd)
        CMD_T: begin
          fld = p / 3;
          sub = p % 3;
          t8  = temps_i[fld*8 +: 8];
          mag = t8[7] ? (8'd0 - t8) : t8;
          if (sub == 0)      nxt_byte = t8[7] ? 8'h2D : 8'h2B;
          else if (sub == 1) nxt_byte = hex_ch(mag[7:4]);
          else               nxt_byte = hex_ch(mag[3:0]);
        end
        CMD_V: begin
          fld = p / 4;
          sub = p % 4;
          v16 = volts_i[fld*16 +: 16];
          nxt_byte = hex_ch(v16[(3-sub)*4 +: 4]);
        end
        CMD_F:   nxt_byte = hex_ch(f24[(5-p)*4 +: 4]);
        default: nxt_byte = CH_EOF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q      <= CMD_S;
      idx_q      <= '0;
      tx_data_o  <= '0;
      tx_valid_o <= 1'b0;
      shut_o     <= 1'b0;
    end else begin
      shut_o <= q_pop_o && (in_cmd == CMD_S);
      if (q_pop_o) begin
        cmd_q      <= in_cmd;
        idx_q      <= '0;
        tx_data_o  <= nxt_byte;
        tx_valid_o <= 1'b1;
      end else if (advance) begin
        if (idx_q == last_of(cmd_q)) begin
          tx_valid_o <= 1'b0;
        end else begin
          idx_q     <= sel_idx;
          tx_data_o <= nxt_byte;
        end
      end
    end
  end
endmodule

// File: rtl/sup_button_timer.sv
module sup_button_timer #(
  parameter int CLK_PER_MS = 200000,
  parameter int HOLD_MS    = 5000
) (
  input  logic clk,
  input  logic rst,
  input  logic button_i,
  output logic irq_n_o,
  output logic force_o
);
  localparam int LIMIT = CLK_PER_MS * HOLD_MS;
  localparam int PW    = $clog2(CLK_PER_MS + 1);
  localparam int HW    = $clog2(LIMIT + 2);

  logic          btn_q;
  logic [PW-1:0] irq_cnt_q;
  logic [HW-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      btn_q     <= 1'b0;
      irq_cnt_q <= '0;
      irq_n_o   <= 1'b1;
      hold_q    <= '0;
      force_o   <= 1'b0;
    end else begin
      btn_q <= button_i;
      if (button_i && !btn_q) begin
        irq_cnt_q <= PW'(CLK_PER_MS - 1);
        irq_n_o   <= 1'b0;
      end else if (irq_cnt_q != '0) begin
        irq_cnt_q <= irq_cnt_q - 1'b1;
      end else begin
        irq_n_o <= 1'b1;
      end
      if (!button_i) begin
        hold_q  <= '0;
        force_o <= 1'b0;
      end else begin
        force_o <= (hold_q == HW'(LIMIT));
        if (hold_q != HW'(LIMIT + 1)) hold_q <= hold_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sup_cmd_responder.sv
module sup_cmd_responder
  import sup_pkg::*;
#(
  parameter int CLK_PER_MS = 200000,
  parameter int HOLD_MS    = 5000,
  parameter int N_TEMP     = 3,
  parameter int N_VOLT     = 13,
  parameter int Q_DEPTH    = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [7:0]           rx_data_i,
  input  logic                 rx_valid_i,
  output logic                 rx_ready_o,
  output logic [7:0]           tx_data_o,
  output logic                 tx_valid_o,
  input  logic                 tx_ready_i,
  input  logic [8*N_TEMP-1:0]  temps_i,
  input  logic [16*N_VOLT-1:0] volts_i,
  input  logic [7:0]           fan_pwm_i,
  input  logic [15:0]          fan_rpm_i,
  input  logic                 button_i,
  output logic                 irq_n_o,
  output logic                 pwr_off_o
);
  logic       take, push, q_full, q_empty, pop, shut, force_off;
  logic [1:0] push_cmd, head_cmd;

  assign rx_ready_o = !q_full;
  assign take       = rx_valid_i && rx_ready_o;
  assign pwr_off_o  = shut || force_off;

  sup_rx_parser parser_i (
    .clk(clk), .rst(rst), .byte_i(rx_data_i), .take_i(take),
    .push_o(push), .cmd_o(push_cmd)
  );

  sup_cmd_fifo #(.W(2), .DEPTH(Q_DEPTH)) queue_i (
    .clk(clk), .rst(rst), .push_i(push), .wdata_i(push_cmd), .pop_i(pop),
    .rdata_o(head_cmd), .empty_o(q_empty), .full_o(q_full)
  );

  sup_resp_fmt #(.N_TEMP(N_TEMP), .N_VOLT(N_VOLT)) fmt_i (
    .clk(clk), .rst(rst), .q_empty_i(q_empty), .q_cmd_i(head_cmd), .q_pop_o(pop),
    .temps_i(temps_i), .volts_i(volts_i), .pwm_i(fan_pwm_i), .rpm_i(fan_rpm_i),
    .tx_data_o(tx_data_o), .tx_valid_o(tx_valid_o), .tx_ready_i(tx_ready_i),
    .shut_o(shut)
  );

  sup_button_timer #(.CLK_PER_MS(CLK_PER_MS), .HOLD_MS(HOLD_MS)) button_i_tmr (
    .clk(clk), .rst(rst), .button_i(button_i), .irq_n_o(irq_n_o), .force_o(force_off)
  );
endmodule

// File: rtl/sup_cmd_responder_chk.sv
module sup_cmd_responder_chk (
  input logic       clk,
  input logic       rst,
  input logic [7:0] tx_data_o,
  input logic       tx_valid_o,
  input logic       tx_ready_i,
  input logic       button_i,
  input logic       irq_n_o
);
  // R4
  tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o)));

  // R4
  frame_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_valid_o) |-> (tx_data_o == 8'h24));

  // R4
  frame_end_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_valid_o && tx_ready_i && tx_data_o == 8'h0A) |=> !tx_valid_o);

  // R9
  irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(irq_n_o) |-> ($past(button_i) && !$past(button_i, 2)));
endmodule

bind sup_cmd_responder sup_cmd_responder_chk chk_i (
  .clk(clk), .rst(rst), .tx_data_o(tx_data_o), .tx_valid_o(tx_valid_o),
  .tx_ready_i(tx_ready_i), .button_i(button_i), .irq_n_o(irq_n_o)
);

// File: tb/sup_cmd_responder_tb_top.sv
`timescale 1ns/1ps
module sup_cmd_responder_tb_top;
  localparam int CPM = 4;
  localparam int HMS = 3;
  localparam int NT  = 3;
  localparam int NV  = 13;
  localparam int LIM = CPM * HMS;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] rx_data = '0;
  logic rx_valid = 1'b0, rx_ready;
  logic [7:0] tx_data;
  logic tx_valid, tx_ready = 1'b1;
  logic [8*NT-1:0] temps;
  logic [16*NV-1:0] volts;
  logic [7:0] pwm = '0;
  logic [15:0] rpm = '0;
  logic button = 1'b0;
  logic irq_n, pwr_off;

  int tb_t [NT];
  logic [15:0] tb_v [NV];
  logic [7:0] exp_q [$];
  logic [7:0] got_q [$];
  int checks = 0, fails = 0, pwr_cnt = 0, cyc = 0;
  bit throttle = 0, stalled = 0;

  always #2.5 clk = ~clk;

  always_comb begin
    for (int i = 0; i < NT; i++) temps[i*8 +: 8] = 8'(tb_t[i]);
    for (int i = 0; i < NV; i++) volts[i*16 +: 16] = tb_v[i];
  end

  sup_cmd_responder #(.CLK_PER_MS(CPM), .HOLD_MS(HMS), .N_TEMP(NT), .N_VOLT(NV), .Q_DEPTH(4)) dut_i (
    .clk(clk), .rst(rst), .rx_data_i(rx_data), .rx_valid_i(rx_valid), .rx_ready_o(rx_ready),
    .tx_data_o(tx_data), .tx_valid_o(tx_valid), .tx_ready_i(tx_ready),
    .temps_i(temps), .volts_i(volts), .fan_pwm_i(pwm), .fan_rpm_i(rpm),
    .button_i(button), .irq_n_o(irq_n), .pwr_off_o(pwr_off)
  );

  // Serialiser model and pulse counter, both at the falling edge.
  always @(negedge clk) begin
    cyc++;
    tx_ready = throttle ? (cyc % 4 == 0) : 1'b1;
    if (!rst && tx_valid && tx_ready) got_q.push_back(tx_data);
    if (!rst && pwr_off) pwr_cnt++;
  end

  function automatic logic [7:0] hc(input int n);
    return (n < 10) ? 8'(48 + n) : 8'(55 + n);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    while (!rx_ready) begin stalled = 1; @(negedge clk); end
    rx_data = b; rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic send_str(input string s);
    for (int i = 0; i < s.len(); i++) send_byte(s[i]);
  endtask

  task automatic exp_s(); exp_q.push_back(8'h24); exp_q.push_back("s"); exp_q.push_back(8'h0A); endtask

  task automatic exp_t();
    exp_q.push_back(8'h24); exp_q.push_back("t");
    for (int i = 0; i < NT; i++) begin
      int m;
      m = (tb_t[i] < 0) ? -tb_t[i] : tb_t[i];
      exp_q.push_back((tb_t[i] < 0) ? "-" : "+");
      exp_q.push_back(hc(m / 16)); exp_q.push_back(hc(m % 16));
    end
    exp_q.push_back(8'h0A);
  endtask

  task automatic exp_v();
    exp_q.push_back(8'h24); exp_q.push_back("v");
    for (int i = 0; i < NV; i++)
      for (int d = 3; d >= 0; d--) exp_q.push_back(hc((int'(tb_v[i]) >> (4*d)) % 16));
    exp_q.push_back(8'h0A);
  endtask

  task automatic exp_f();
    exp_q.push_back(8'h24); exp_q.push_back("f");
    exp_q.push_back(hc(int'(pwm) / 16)); exp_q.push_back(hc(int'(pwm) % 16));
    for (int d = 3; d >= 0; d--) exp_q.push_back(hc((int'(rpm) >> (4*d)) % 16));
    exp_q.push_back(8'h0A);
  endtask

  task automatic drain_and_compare(input string req);
    int guard = 0;
    int bad = -1;
    while ((got_q.size() < exp_q.size() || tx_valid) && guard < 20000) begin
      @(negedge clk); guard++;
    end
    repeat (6) @(negedge clk);
    if (got_q.size() == exp_q.size())
      for (int i = 0; i < exp_q.size(); i++) if (bad < 0 && got_q[i] != exp_q[i]) bad = i;
    if (got_q.size() != exp_q.size()) check(0, {req, " length"}, got_q.size(), exp_q.size());
    else if (bad >= 0) check(0, {req, " byte"}, got_q[bad], exp_q[bad]);
    else check(1, req, 0, 0);
    got_q.delete(); exp_q.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog all requirements actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int base;
    for (int i = 0; i < NT; i++) tb_t[i] = 0;
    for (int i = 0; i < NV; i++) tb_v[i] = '0;
    repeat (4) @(negedge clk);
    // R11 reset values
    check(!tx_valid && irq_n && !pwr_off && rx_ready, "R11 reset state",
          {tx_valid, irq_n, pwr_off, rx_ready}, 4'b0101);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // R6 temperature sweep including 0, -1, 127, -128
    for (int k = 0; k < 12; k++) begin
      tb_t[0] = k * 23 - 128;
      tb_t[1] = 127 - k * 21;
      tb_t[2] = (k == 5) ? 0 : -k;
      send_str("#t\n"); exp_t();
      drain_and_compare("R6 temperature reply");
    end

    // R7 voltage patterns
    for (int p = 0; p < 4; p++) begin
      for (int i = 0; i < NV; i++)
        tb_v[i] = (p == 3) ? 16'hFFFF : {8'(i + p * 5), 8'((i * 37 + p * 71) % 256)};
      send_str("#v\n"); exp_v();
      drain_and_compare("R7 voltage reply");
    end

    // R8 fan values
    for (int p = 0; p < 4; p++) begin
      pwm = 8'(p * 84); rpm = 16'(p * 21845);
      send_str("#f\n"); exp_f();
      drain_and_compare("R8 fan reply");
    end

    // R5 shutdown
    base = pwr_cnt;
    send_str("#s\n"); exp_s();
    drain_and_compare("R5 shutdown reply");
    check(pwr_cnt - base == 1, "R5 power-off pulse count", pwr_cnt - base, 1);

    // R2 malformed frames, then R1 a good frame with restarted framing
    base = pwr_cnt;
    send_str("s\n#x\n#tq\n#\n#s#s"); send_str("\n");
    exp_s();
    drain_and_compare("R1 R2 only restarted frame answered");
    check(pwr_cnt - base == 1, "R2 no pulse from bad frames", pwr_cnt - base, 1);
    base = pwr_cnt;
    send_str("f\n#q\n#vv\n"); send_str("#f\n"); exp_f();
    drain_and_compare("R2 discarded frames");
    check(pwr_cnt == base, "R2 no shutdown pulse", pwr_cnt - base, 0);

    // R3 R4 pipelined commands with a slow serialiser
    base = pwr_cnt; throttle = 1; stalled = 0;
    tb_t[0] = 45; tb_t[1] = -77; tb_t[2] = 3;
    send_str("#v\n#t\n#s\n#f\n#t\n#f\n");
    exp_v(); exp_t(); exp_s(); exp_f(); exp_t(); exp_f();
    drain_and_compare("R3 R4 ordered pipelined replies");
    check(stalled, "R3 rx_ready low while queue full", stalled, 1);
    check(pwr_cnt - base == 1, "R5 pulse in pipeline", pwr_cnt - base, 1);
    throttle = 0;

    // R9 short press
    begin
      int low = 0, first = -1;
      base = pwr_cnt;
      @(negedge clk); button = 1'b1;
      for (int k = 1; k <= CPM + 6; k++) begin
        @(negedge clk);
        if (k == 2) button = 1'b0;
        if (!irq_n) begin low++; if (first < 0) first = k; end
      end
      check(low == CPM, "R9 pulse length", low, CPM);
      check(first == 1, "R9 pulse start", first, 1);
      check(pwr_cnt == base, "R10 short press no power-off", pwr_cnt - base, 0);
    end

    // R10 long press
    begin
      int at = -1;
      repeat (4) @(negedge clk);
      base = pwr_cnt;
      button = 1'b1;
      for (int k = 1; k <= 3 * LIM; k++) begin
        @(negedge clk);
        if (pwr_off && at < 0) at = k;
      end
      button = 1'b0;
      repeat (4) @(negedge clk);
      check(at == LIM + 1, "R10 forced power-off timing", at, LIM + 1);
      check(pwr_cnt - base == 1, "R10 single pulse while held", pwr_cnt - base, 1);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule